// File: doc/BRIEF.md
# Variable-Page Translation Lookup

This block translates a virtual address into a physical address by comparing it against every entry of a fully associative translation buffer at once. Each entry states its own page size, so one entry can cover a 1 KB page and another a 16 MB region. An entry matches only when its stored address space tag is zero or equals the current address space number. A shared zone register can widen or narrow the permissions an entry grants, depending on the zone the entry belongs to and on whether the access comes from user or supervisor code.

The lookup logic is combinational. Its result is captured in a register on the clock edge where `lookup_valid` is high and appears on the outputs one cycle later, qualified by `out_valid`. The entry arrays come in as flat buses: entry `i` occupies bits `[32*i+31:32*i]` of `tag_words` and `data_words`, and bits `[8*i+7:8*i]` of `tid_words`. The logic that loads the entries, walks the page tables and raises exceptions lies outside this block.

Top module: `tlbv_lookup`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` and `out_hit` read 0 until the first lookup is taken.
- R2: A lookup presented with `lookup_valid` high on a rising edge produces `out_valid` high for exactly the next cycle. A cycle without `lookup_valid` leaves `out_valid` low in the following cycle.
- R3: Tag bits [9:7] hold a size code c that selects a page of 2^(10+2c) bytes (1 KB, 4 KB, 16 KB, 64 KB, 256 KB, 1 MB, 4 MB, 16 MB). The virtual address matches the tag when both agree on every bit at or above bit 10+2c.
- R4: An entry whose valid bit, tag bit 6, is clear never matches.
- R5: An entry with a nonzero 8-bit tid matches only when the tid equals `pid_reg[7:0]`. A tid of zero matches under any `pid_reg`.
- R6: When several entries match, `out_idx` reports the lowest matching index and the result is taken from that entry.
- R7: On a hit, `out_paddr` takes the page bits (bit 10+2c and above) from data bits [31:10], takes the offset bits below them from the virtual address, and is then ANDed with the parameter `PA_MASK` (default 0x3FFF_FFFF).
- R8: Data bits [7:4] give the zone number z. The zone code is `zone_reg[31-2z:30-2z]`. The code is forced to 01 when z exceeds the parameter `ZONE_LIMIT` (default 7) or when the parameter `ZONES_ON` is 0.
- R9: Data bit 8 is the entry's write enable and data bit 9 its execute enable. Zone code 00 grants nothing to user mode and grants the entry's rights to supervisor mode. Code 01 grants the entry's rights in both modes. Code 10 grants the entry's rights to user mode and full rights to supervisor mode. Code 11 grants full rights in both modes. "Entry's rights" means read plus the two enable bits; "full" means read, write and execute.
- R10: `acc_kind` encodes 0 as read, 1 as write, 2 as fetch and 3 as reserved. `out_acc_ok` is high only on a hit whose granted rights include the requested kind, and it is never high for kind 3.
- R11: On a miss, `out_hit`, `out_rd`, `out_wr`, `out_ex` and `out_acc_ok` are 0, and `out_idx` and `out_paddr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lookup_valid | input | 1 | Take a lookup on this edge |
| vaddr | input | 32 | Virtual address |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| user_mode | input | 1 | 1 for a user-mode access |
| pid_reg | input | 32 | Current address space number (low 8 bits used) |
| zone_reg | input | 32 | Sixteen 2-bit zone codes, zone 0 at the top |
| tag_words | input | 32*N_ENT | Tag word of every entry |
| tid_words | input | 8*N_ENT | Address space tag of every entry |
| data_words | input | 32*N_ENT | Data word of every entry |
| out_valid | output | 1 | Result present this cycle |
| out_hit | output | 1 | An entry matched |
| out_idx | output | $clog2(N_ENT) | Index of the chosen entry |
| out_paddr | output | 32 | Translated address |
| out_rd | output | 1 | Read granted |
| out_wr | output | 1 | Write granted |
| out_ex | output | 1 | Execute granted |
| out_acc_ok | output | 1 | Requested access granted |

## Verification
The bench probes both sides of each page boundary for the 1 KB, 4 KB and 16 MB sizes. A mask that is off by one size step would then translate the address just past the boundary, or miss the last byte inside the page. Overlapping entries check that the lowest index wins; a picker that favours the highest index reports the wrong entry and address. The tid cases include a number that differs only above bit 7 and a wildcard entry, so a full-width compare or a missing wildcard fails. The zone cases cover each code in both modes, a zone above the limit whose raw code is 00, and the reserved access kind, so a swapped mode meaning or a missing override shows up as wrong rights.

// File: rtl/tlbv_pkg.sv
package tlbv_pkg;

  localparam int unsigned AW        = 32;
  localparam int unsigned VALID_BIT = 6;
  localparam int unsigned SZ_LO     = 7;
  localparam int unsigned SZ_HI     = 9;
  localparam int unsigned WE_BIT    = 8;
  localparam int unsigned XE_BIT    = 9;
  localparam int unsigned ZS_LO     = 4;
  localparam int unsigned ZS_HI     = 7;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } rights_t;

  // Keep-mask for a size code: bits at or above 10+2*code are page bits.
  function automatic logic [AW-1:0] page_keep(input logic [2:0] code);
    logic [4:0] sh;
    sh = 5'd10 + {1'b0, code, 1'b0};
    return ~((32'd1 << sh) - 32'd1);
  endfunction

  // Raw 2-bit code of zone z; zone 0 sits in the top two bits.
  function automatic logic [1:0] zone_raw(input logic [AW-1:0] zr, input logic [3:0] z);
    logic [5:0] sh;
    sh = 6'd30 - {1'b0, z, 1'b0};
    return 2'(zr >> sh);
  endfunction

endpackage

// File: rtl/tlbv_entry_cmp.sv
module tlbv_entry_cmp
  import tlbv_pkg::*;
(
  input  logic [AW-1:0] vaddr,
  input  logic [AW-1:0] tag_word,
  input  logic [7:0]    tid,
  input  logic [7:0]    pid8,
  output logic          match
);
  logic [AW-1:0] keep;
  logic          addr_eq;
  logic          space_ok;

  assign keep     = page_keep(tag_word[SZ_HI:SZ_LO]);
  assign addr_eq  = ((vaddr ^ tag_word) & keep) == '0;
  assign space_ok = (tid == 8'd0) || (tid == pid8);
  assign match    = tag_word[VALID_BIT] & addr_eq & space_ok;
endmodule

// File: rtl/tlbv_pick.sv
module tlbv_pick #(
  parameter int N_ENT = 64,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0] match_vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlbv_rights.sv
module tlbv_rights
  import tlbv_pkg::*;
#(
  parameter int ZONE_LIMIT = 7,
  parameter bit ZONES_ON   = 1'b1
) (
  input  logic [AW-1:0] data_word,
  input  logic [AW-1:0] zone_reg,
  input  logic          user_mode,
  input  logic [1:0]    acc_kind,
  output logic [1:0]    zone_eff,
  output rights_t       grant,
  output logic          kind_ok
);
  logic [3:0] zsel;
  rights_t    own;
  rights_t    full;
  logic       unused_bits;

  assign zsel        = data_word[ZS_HI:ZS_LO];
  assign own         = '{rd: 1'b1, wr: data_word[WE_BIT], ex: data_word[XE_BIT]};
  assign full        = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
  assign unused_bits = ^{data_word[AW-1:10], data_word[3:0]};

  always_comb begin
    if (!ZONES_ON || (int'(zsel) > ZONE_LIMIT)) zone_eff = 2'b01;
    else                                       zone_eff = zone_raw(zone_reg, zsel);
  end

  always_comb begin
    unique case (zone_eff)
      2'b00:   grant = user_mode ? rights_t'('0) : own;
      2'b01:   grant = own;
      2'b10:   grant = user_mode ? own : full;
      default: grant = full;
    endcase
  end

  always_comb begin
    unique case (acc_kind)
      2'd0:    kind_ok = grant.rd;
      2'd1:    kind_ok = grant.wr;
      2'd2:    kind_ok = grant.ex;
      default: kind_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlbv_lookup.sv
module tlbv_lookup
  import tlbv_pkg::*;
#(
  parameter int          N_ENT      = 64,
  parameter int          ZONE_LIMIT = 7,
  parameter bit          ZONES_ON   = 1'b1,
  parameter logic [31:0] PA_MASK    = 32'h3FFF_FFFF,
  localparam int         IDX_W      = $clog2(N_ENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lookup_valid,
  input  logic [31:0]        vaddr,
  input  logic [1:0]         acc_kind,
  input  logic               user_mode,
  input  logic [31:0]        pid_reg,
  input  logic [31:0]        zone_reg,
  input  logic [32*N_ENT-1:0] tag_words,
  input  logic [8*N_ENT-1:0]  tid_words,
  input  logic [32*N_ENT-1:0] data_words,
  output logic               out_valid,
  output logic               out_hit,
  output logic [IDX_W-1:0]   out_idx,
  output logic [31:0]        out_paddr,
  output logic               out_rd,
  output logic               out_wr,
  output logic               out_ex,
  output logic               out_acc_ok
);
  logic [N_ENT-1:0] match_vec;
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic [31:0]      sel_tag;
  logic [31:0]      sel_data;
  logic [31:0]      sel_keep;
  logic [31:0]      pa_comb;
  logic [1:0]       zone_eff;
  rights_t          grant;
  logic             kind_ok;
  logic [N_ENT-1:0] below_mask;
  logic             unused_bits;

  assign unused_bits = ^pid_reg[31:8];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    tlbv_entry_cmp u_cmp (
      .vaddr    (vaddr),
      .tag_word (tag_words[32*g +: 32]),
      .tid      (tid_words[8*g +: 8]),
      .pid8     (pid_reg[7:0]),
      .match    (match_vec[g])
    );
  end

  tlbv_pick #(.N_ENT(N_ENT)) u_pick (
    .match_vec (match_vec),
    .any       (pick_any),
    .idx       (pick_idx)
  );

  assign sel_tag  = tag_words[32*pick_idx +: 32];
  assign sel_data = data_words[32*pick_idx +: 32];
  assign sel_keep = page_keep(sel_tag[SZ_HI:SZ_LO]);
  assign pa_comb  = ((sel_data & sel_keep) | (vaddr & ~sel_keep)) & PA_MASK;

  tlbv_rights #(.ZONE_LIMIT(ZONE_LIMIT), .ZONES_ON(ZONES_ON)) u_rights (
    .data_word (sel_data),
    .zone_reg  (zone_reg),
    .user_mode (user_mode),
    .acc_kind  (acc_kind),
    .zone_eff  (zone_eff),
    .grant     (grant),
    .kind_ok   (kind_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_hit    <= 1'b0;
      out_idx    <= '0;
      out_paddr  <= '0;
      out_rd     <= 1'b0;
      out_wr     <= 1'b0;
      out_ex     <= 1'b0;
      out_acc_ok <= 1'b0;
    end else begin
      out_valid <= lookup_valid;
      if (lookup_valid) begin
        out_hit    <= pick_any;
        out_idx    <= pick_any ? pick_idx : '0;
        out_paddr  <= pick_any ? pa_comb : '0;
        out_rd     <= pick_any & grant.rd;
        out_wr     <= pick_any & grant.wr;
        out_ex     <= pick_any & grant.ex;
        out_acc_ok <= pick_any & kind_ok;
      end
    end
  end

  // Assertions
  assign below_mask = (N_ENT'(1) << pick_idx) - N_ENT'(1);

  p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> out_valid);

  p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |=> !out_valid);

  p_pick_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pick_any |-> (match_vec[pick_idx] && ((match_vec & below_mask) == '0)));

  p_miss_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (!out_rd && !out_wr && !out_ex && !out_acc_ok
                                 && out_idx == '0 && out_paddr == '0));

  p_user_zone_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && pick_any && user_mode && zone_eff == 2'b00)
      |=> (!out_rd && !out_wr && !out_ex));

  p_ok_needs_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_acc_ok |-> (out_hit && (out_rd || out_wr || out_ex)));

  p_paddr_in_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_paddr & ~PA_MASK) == '0));
endmodule

// File: tb/sim_tlbv_lookup.sv
module sim_tlbv_lookup;
  localparam int N = 64;

  typedef struct {
    bit          hit;
    int          idx;
    logic [31:0] pa;
    bit          rd, wr, ex, ok;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lookup_valid = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  acc_kind = '0;
  logic        user_mode = 1'b0;
  logic [31:0] pid_reg = '0;
  logic [31:0] zone_reg = '0;
  logic [31:0] tg [N];
  logic [7:0]  td [N];
  logic [31:0] dt [N];
  logic [32*N-1:0] tag_flat;
  logic [8*N-1:0]  tid_flat;
  logic [32*N-1:0] dat_flat;

  logic        out_valid, out_hit, out_rd, out_wr, out_ex, out_acc_ok;
  logic [5:0]  out_idx;
  logic [31:0] out_paddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      tag_flat[32*i +: 32] = tg[i];
      tid_flat[8*i +: 8]   = td[i];
      dat_flat[32*i +: 32] = dt[i];
    end
  end

  tlbv_lookup u0 (
    .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid), .vaddr(vaddr),
    .acc_kind(acc_kind), .user_mode(user_mode), .pid_reg(pid_reg),
    .zone_reg(zone_reg), .tag_words(tag_flat), .tid_words(tid_flat),
    .data_words(dat_flat), .out_valid(out_valid), .out_hit(out_hit),
    .out_idx(out_idx), .out_paddr(out_paddr), .out_rd(out_rd),
    .out_wr(out_wr), .out_ex(out_ex), .out_acc_ok(out_acc_ok)
  );

  // Reference model written from the requirements.
  function automatic exp_t model(input logic [31:0] va, input logic [1:0] k,
                                 input bit usr, input string req);
    exp_t e;
    int   sh;
    int   z;
    logic [1:0] zc;
    logic [31:0] d;
    bit own_w, own_x;
    e = '{hit: 0, idx: 0, pa: 32'd0, rd: 0, wr: 0, ex: 0, ok: 0, req: req};
    sh = 0;
    for (int i = 0; i < N; i++) begin
      int s;
      s = 10 + 2 * int'(tg[i][9:7]);
      if (tg[i][6] && ((va >> s) == (tg[i] >> s)) &&
          (td[i] == 8'd0 || td[i] == pid_reg[7:0])) begin
        e.hit = 1; e.idx = i; sh = s;
        break;
      end
    end
    if (!e.hit) return e;
    d = dt[e.idx];
    e.pa = (((d >> sh) << sh) | (va % (32'd1 << sh))) & 32'h3FFF_FFFF;
    z = int'(d[7:4]);
    zc = (z > 7) ? 2'b01 : {zone_reg[31 - 2*z], zone_reg[30 - 2*z]};
    own_w = d[8];
    own_x = d[9];
    if (zc == 2'b11 || (zc == 2'b10 && !usr)) begin
      e.rd = 1; e.wr = 1; e.ex = 1;
    end else if (zc == 2'b00 && usr) begin
      e.rd = 0; e.wr = 0; e.ex = 0;
    end else begin
      e.rd = 1; e.wr = own_w; e.ex = own_x;
    end
    e.ok = (k == 2'd0) ? e.rd : (k == 2'd1) ? e.wr : (k == 2'd2) ? e.ex : 1'b0;
    return e;
  endfunction

  task automatic look(input logic [31:0] va, input logic [1:0] k, input bit usr,
                      input string req);
    @(negedge clk);
    vaddr = va; acc_kind = k; user_mode = usr; lookup_valid = 1'b1;
    q.push_back(model(va, k, usr, req));
  endtask

  task automatic idle();
    @(negedge clk);
    lookup_valid = 1'b0;
  endtask

  // Monitor: compare each result one cycle after its request.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected result actual=valid expected=none");
      end else begin
        exp_t e;
        e = q.pop_front();
        if (out_hit !== e.hit || (e.hit && out_idx !== 6'(e.idx)) ||
            out_paddr !== e.pa || out_rd !== e.rd || out_wr !== e.wr ||
            out_ex !== e.ex || out_acc_ok !== e.ok) begin
          errors++;
          $display("FAIL %s actual hit=%0d idx=%0d pa=%h rwx=%0d%0d%0d ok=%0d expected hit=%0d idx=%0d pa=%h rwx=%0d%0d%0d ok=%0d",
                   e.req, out_hit, out_idx, out_paddr, out_rd, out_wr, out_ex, out_acc_ok,
                   e.hit, e.idx, e.pa, e.rd, e.wr, e.ex, e.ok);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      tg[i] = '0; td[i] = '0; dt[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || out_hit !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset actual=%0d/%0d expected=0/0", out_valid, out_hit);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_hit !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset actual=%0d/%0d expected=0/0", out_valid, out_hit);
    end

    zone_reg = 32'h4B00_0000; // zone0=01 zone1=00 zone2=10 zone3=11
    pid_reg  = 32'h0000_0021;
    // 4 KB page, zone 0, write+exec
    tg[3] = 32'h1234_5000 | (32'd1 << 7) | 32'h40;  dt[3] = 32'h0ABC_D000 | 32'h300;
    // 16 MB page, zone 0, read only
    tg[5] = 32'h4000_0000 | (32'd7 << 7) | 32'h40;  dt[5] = 32'h8100_0000;
    // 1 KB page
    tg[6] = 32'h0000_2400 | 32'h40;                dt[6] = 32'h0001_0C00 | 32'h100;
    // invalid 4 KB entry
    tg[8] = 32'h5000_0000 | (32'd1 << 7);          dt[8] = 32'h0002_0000;
    // tid-restricted entry
    tg[9] = 32'h6000_0000 | (32'd1 << 7) | 32'h40;  td[9] = 8'h21; dt[9] = 32'h0003_0000;
    // overlapping entries 10 (4 KB) and 12 (64 KB)
    tg[10] = 32'h7000_0000 | (32'd1 << 7) | 32'h40; dt[10] = 32'h0004_0000;
    tg[12] = 32'h7000_0000 | (32'd3 << 7) | 32'h40; dt[12] = 32'h0050_0000;
    // zone test entry
    tg[13] = 32'h9000_0000 | (32'd1 << 7) | 32'h40; dt[13] = 32'h0006_0000;

    look(32'h1234_5678, 2'd0, 1'b0, "R3 4K inside");
    look(32'h1234_6000, 2'd0, 1'b0, "R3 4K just past");
    look(32'h1234_4FFF, 2'd0, 1'b0, "R3 4K just below");
    look(32'h40FF_FFF0, 2'd0, 1'b0, "R7 16M offset and mask");
    look(32'h4100_0000, 2'd0, 1'b0, "R3 16M past");
    look(32'h0000_27FF, 2'd1, 1'b0, "R3 1K last byte");
    look(32'h0000_2800, 2'd0, 1'b0, "R3 1K past");
    look(32'h5000_0010, 2'd0, 1'b0, "R4 invalid entry");
    idle();
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2 idle cycle actual=%0d expected=0", out_valid);
    end

    look(32'h6000_0004, 2'd0, 1'b0, "R5 tid equal");
    idle(); pid_reg = 32'h0000_0022;
    look(32'h6000_0004, 2'd0, 1'b0, "R5 tid differs");
    look(32'h1234_5000, 2'd0, 1'b0, "R5 zero tid wildcard");
    idle(); pid_reg = 32'h0000_0121;
    look(32'h6000_0004, 2'd0, 1'b0, "R5 only low 8 bits");
    look(32'h7000_0010, 2'd0, 1'b0, "R6 lowest index");
    look(32'h7000_1010, 2'd0, 1'b0, "R6 wider entry only");
    look(32'hFFFF_F000, 2'd0, 1'b0, "R11 miss");

    // zone codes, entry rights: write off, exec on
    idle(); dt[13] = 32'h0006_0000 | 32'h200 | (32'd1 << 4);
    look(32'h9000_0000, 2'd0, 1'b1, "R9 zone00 user none");
    look(32'h9000_0000, 2'd2, 1'b0, "R9 zone00 supervisor entry");
    idle(); dt[13] = 32'h0006_0000 | 32'h200 | (32'd2 << 4);
    look(32'h9000_0000, 2'd1, 1'b1, "R9 zone10 user entry");
    look(32'h9000_0000, 2'd1, 1'b0, "R9 zone10 supervisor full");
    idle(); dt[13] = 32'h0006_0000 | (32'd3 << 4);
    look(32'h9000_0000, 2'd1, 1'b1, "R9 zone11 user full");
    idle(); dt[13] = 32'h0006_0000 | 32'h200;
    look(32'h9000_0000, 2'd1, 1'b1, "R10 zone01 write denied");
    look(32'h9000_0000, 2'd2, 1'b1, "R10 fetch granted");
    look(32'h9000_0000, 2'd3, 1'b0, "R10 reserved kind");
    idle(); dt[13] = 32'h0006_0000 | 32'h100 | (32'd8 << 4);
    look(32'h9000_0000, 2'd1, 1'b1, "R8 zone above limit forced");
    idle(); dt[13] = 32'h0006_0000 | (32'd15 << 4); zone_reg = 32'h0000_0003;
    look(32'h9000_0000, 2'd1, 1'b1, "R8 zone bits at bottom");
    idle();
    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2 results missing actual=%0d expected=0", q.size());
    end
    finish_run();
  end
endmodule